// File: doc/BRIEF.md
# Core idle state controller

This block steers a single processor core through its idle states: running (C0), halted with clock on (C1), flushed and clock-stopped (C3), and state-saved and clock-stopped (C6). A request to go idle comes from a wait instruction that carries a depth hint, or from decoded reads of the level-2 or level-3 power-level I/O ports. The block does not move or store any data. It asks a cache-flush engine to empty the core caches before C3. It asks a save/restore engine to move register state into the last-level cache before C6, and to bring that state back after C6. It also gates the core clock.

An interrupt wakes the core. A reset puts it back into C0 at once. The state the core is actually in is reported on a 3-bit code that a package-level resolver compares across cores. A larger code means a deeper idle state. The handshakes follow a fixed order. The flush completes before C3 is reported. The save completes before C6 is reported. On C6 exit the clock comes back first, then the restore runs, and C0 is reported only once the restore has finished. An interrupt that arrives during a flush or a save does not cut the handshake short: the block waits for the acknowledge and then returns to C0.

Top module: `core_idle_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, `idle_state` is 0, `core_clk_en` is 1, and `flush_req`, `save_req`, `restore_req` and `snoop_svc` are 0. Asserting reset in any state returns the block to this condition.
- R2: `idle_state` uses these codes: 0 = C0, 1 = C1, 3 = C3, 6 = C6. From C0, a wait hint with `wait_hint_lvl` = 0 reports code 1 from the next cycle, and `core_clk_en` stays 1 while in C1.
- R3: From C0, a level-2 power read or a wait hint with level 1 raises `flush_req` in the next cycle, with `idle_state` still 0 and the clock on. The request holds until `flush_done` is sampled high. In the cycle after that, `idle_state` is 3, `core_clk_en` is 0 and `flush_req` is 0.
- R4: From C0, a level-3 power read or a wait hint with level 2 or 3 raises `save_req` in the next cycle, with `idle_state` still 0. The request holds until `save_done` is sampled high. In the cycle after that, `idle_state` is 6 and `core_clk_en` is 0.
- R5: When several entry requests arrive in the same cycle, the deepest one wins. Entry requests are ignored in any state other than C0. An interrupt in the same cycle as an entry request in C0 cancels that request.
- R6: A snoop never changes the state. `snoop_svc` goes high one cycle after `snoop` while the core clock is enabled (including C1), and stays 0 for snoops that arrive while the clock is stopped (C3, C6).
- R7: An interrupt in C1 or C3 reports C0 with `core_clk_en` = 1 in the next cycle. Without an interrupt, C3 is held indefinitely.
- R8: An interrupt in C6 sets `core_clk_en` and `restore_req` in the next cycle while `idle_state` stays 6. One cycle after `restore_done` is sampled high, `idle_state` is 0 and `restore_req` is 0.
- R9: An interrupt seen at any point during a flush or a save (including the acknowledge cycle) aborts the entry. One cycle after the acknowledge, the block is in C0 with the clock on and no restore.
- R10: At most one of `flush_req`, `save_req`, `restore_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (always running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_hint_vld | input | 1 | Wait instruction idle request, one-cycle pulse |
| wait_hint_lvl | input | 2 | Hint depth: 0 = C1, 1 = C3, 2 or 3 = C6 |
| pwr_rd_l2 | input | 1 | Decoded level-2 power I/O read (C3 request) |
| pwr_rd_l3 | input | 1 | Decoded level-3 power I/O read (C6 request) |
| irq | input | 1 | Pending interrupt (wake event) |
| snoop | input | 1 | Incoming snoop for this core |
| flush_req | output | 1 | Cache flush request |
| flush_done | input | 1 | Cache flush complete |
| save_req | output | 1 | Register state save request |
| save_done | input | 1 | State save complete |
| restore_req | output | 1 | Register state restore request |
| restore_done | input | 1 | State restore complete |
| core_clk_en | output | 1 | Core clock enable |
| snoop_svc | output | 1 | Snoop serviced by a clocked core, one cycle after `snoop` |
| idle_state | output | 3 | Current idle state code for the package resolver |

## Verification
Every output of this block is a registered result. A state change, a handshake request or a change in the clock enable shows up in the cycle after the edge that sampled the request, the acknowledge or the interrupt. `snoop_svc` shows up one cycle after the snoop, and it reflects whether the clock was enabled in the cycle the snoop arrived. The bench changes inputs just after a falling edge, so the next rising edge samples them. A behavioural model of states and pending handshakes is updated on that same rising edge. Every output is compared with the model at each falling edge, so each result is checked in exactly the cycle it is due. The sequences include back-to-back requests, interrupts that coincide with acknowledges, and a reset taken in the middle of C6.

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_hint_vld,
  input  logic [1:0] wait_hint_lvl,
  input  logic       pwr_rd_l2,
  input  logic       pwr_rd_l3,
  input  logic       irq,
  input  logic       snoop,
  output logic       flush_req,
  input  logic       flush_done,
  output logic       save_req,
  input  logic       save_done,
  output logic       restore_req,
  input  logic       restore_done,
  output logic       core_clk_en,
  output logic       snoop_svc,
  output logic [2:0] idle_state
);

  localparam logic [2:0] CODE_C0 = 3'd0;
  localparam logic [2:0] CODE_C1 = 3'd1;
  localparam logic [2:0] CODE_C3 = 3'd3;
  localparam logic [2:0] CODE_C6 = 3'd6;

  typedef enum logic [2:0] {
    S_RUN, S_HALT, S_FLUSH, S_DOZE, S_SAVE, S_DEEP, S_RESTORE
  } st_t;

  st_t  st, st_nx;
  logic abort_q, abort_nx;

  logic go_c6, go_c3, go_c1;
  assign go_c6 = pwr_rd_l3 | (wait_hint_vld & wait_hint_lvl[1]);
  assign go_c3 = pwr_rd_l2 | (wait_hint_vld & (wait_hint_lvl == 2'd1));
  assign go_c1 = wait_hint_vld & (wait_hint_lvl == 2'd0);

  always_comb begin
    st_nx    = st;
    abort_nx = abort_q;
    case (st)
      S_RUN:
        if (!irq) begin
          if (go_c6)      st_nx = S_SAVE;
          else if (go_c3) st_nx = S_FLUSH;
          else if (go_c1) st_nx = S_HALT;
        end
      S_HALT:
        if (irq) st_nx = S_RUN;
      S_FLUSH: begin
        if (irq) abort_nx = 1'b1;
        if (flush_done) begin
          st_nx    = (abort_q | irq) ? S_RUN : S_DOZE;
          abort_nx = 1'b0;
        end
      end
      S_DOZE:
        if (irq) st_nx = S_RUN;
      S_SAVE: begin
        if (irq) abort_nx = 1'b1;
        if (save_done) begin
          st_nx    = (abort_q | irq) ? S_RUN : S_DEEP;
          abort_nx = 1'b0;
        end
      end
      S_DEEP:
        if (irq) st_nx = S_RESTORE;
      S_RESTORE:
        if (restore_done) st_nx = S_RUN;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      abort_q   <= 1'b0;
      snoop_svc <= 1'b0;
    end else begin
      st        <= st_nx;
      abort_q   <= abort_nx;
      snoop_svc <= snoop & core_clk_en;
    end
  end

  assign flush_req   = (st == S_FLUSH);
  assign save_req    = (st == S_SAVE);
  assign restore_req = (st == S_RESTORE);
  assign core_clk_en = !((st == S_DOZE) || (st == S_DEEP));

  always_comb begin
    case (st)
      S_HALT:            idle_state = CODE_C1;
      S_DOZE:            idle_state = CODE_C3;
      S_DEEP, S_RESTORE: idle_state = CODE_C6;
      default:           idle_state = CODE_C0;
    endcase
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (idle_state == CODE_C0 && core_clk_en)); // R1

  AST_C1_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state == CODE_C1) |-> core_clk_en); // R2

  AST_FLUSH_BEFORE_C3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state == CODE_C3 && $past(idle_state) != CODE_C3) |-> $past(flush_req && flush_done)); // R3

  AST_SAVE_BEFORE_C6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state == CODE_C6 && $past(idle_state) != CODE_C6) |-> $past(save_req && save_done)); // R4

  AST_SNOOP_KEEPS_C3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state == CODE_C3 && !irq) |=> (idle_state == CODE_C3)); // R7

  AST_IRQ_WAKES_C1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state == CODE_C1 && irq) |=> (idle_state == CODE_C0 && core_clk_en)); // R7

  AST_RESTORE_BEFORE_C0: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state == CODE_C0 && $past(idle_state) == CODE_C6) |-> $past(restore_req && restore_done)); // R8

  AST_CLOCK_BEFORE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> core_clk_en); // R8

  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flush_req, save_req, restore_req}) <= 1); // R10

endmodule

// File: tb/core_idle_ctrl_test.sv
module core_idle_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_hint_vld = 1'b0;
  logic [1:0] wait_hint_lvl = 2'd0;
  logic pwr_rd_l2 = 1'b0, pwr_rd_l3 = 1'b0, irq = 1'b0, snoop = 1'b0;
  logic flush_done = 1'b0, save_done = 1'b0, restore_done = 1'b0;
  logic flush_req, save_req, restore_req, core_clk_en, snoop_svc;
  logic [2:0] idle_state;

  core_idle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wait_hint_vld(wait_hint_vld), .wait_hint_lvl(wait_hint_lvl),
    .pwr_rd_l2(pwr_rd_l2), .pwr_rd_l3(pwr_rd_l3), .irq(irq), .snoop(snoop),
    .flush_req(flush_req), .flush_done(flush_done), .save_req(save_req), .save_done(save_done),
    .restore_req(restore_req), .restore_done(restore_done), .core_clk_en(core_clk_en),
    .snoop_svc(snoop_svc), .idle_state(idle_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  // reference model: phase 0 settled, 1 flushing, 2 saving, 3 restoring
  int m_cs = 0, m_clk = 1, m_phase = 0, m_abort = 0, m_svc = 0;

  always @(posedge clk) begin
    int want;
    if (!rst_n) begin
      m_cs = 0; m_clk = 1; m_phase = 0; m_abort = 0; m_svc = 0;
    end else begin
      m_svc = (snoop && m_clk) ? 1 : 0;
      want = 0;
      if (wait_hint_vld) want = (wait_hint_lvl == 0) ? 1 : (wait_hint_lvl == 1) ? 3 : 6;
      if (pwr_rd_l2 && want < 3) want = 3;
      if (pwr_rd_l3) want = 6;
      if (m_phase == 1 || m_phase == 2) begin
        if (irq) m_abort = 1;
        if ((m_phase == 1 && flush_done) || (m_phase == 2 && save_done)) begin
          if (m_abort == 0) begin
            m_cs = (m_phase == 1) ? 3 : 6;
            m_clk = 0;
          end
          m_phase = 0; m_abort = 0;
        end
      end else if (m_phase == 3) begin
        if (restore_done) begin m_cs = 0; m_phase = 0; end
      end else if (m_cs == 0) begin
        if (!irq) begin
          if (want == 1) m_cs = 1;
          else if (want == 3) m_phase = 1;
          else if (want == 6) m_phase = 2;
        end
      end else if (irq) begin
        if (m_cs == 6) begin m_clk = 1; m_phase = 3; end
        else begin m_cs = 0; m_clk = 1; end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("idle_state", int'(idle_state), m_cs);
    chk("core_clk_en", int'(core_clk_en), m_clk);
    chk("flush_req", int'(flush_req), (m_phase == 1) ? 1 : 0);
    chk("save_req", int'(save_req), (m_phase == 2) ? 1 : 0);
    chk("restore_req", int'(restore_req), (m_phase == 3) ? 1 : 0);
    chk("snoop_svc", int'(snoop_svc), m_svc);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_in();
    wait_hint_vld = 0; pwr_rd_l2 = 0; pwr_rd_l3 = 0; irq = 0; snoop = 0;
    flush_done = 0; save_done = 0; restore_done = 0;
  endtask

  task automatic hint(int lvl);
    wait_hint_vld = 1; wait_hint_lvl = 2'(lvl); tick(); clear_in();
  endtask

  task automatic pulse_irq();
    irq = 1; tick(); clear_in();
  endtask

  task automatic pulse_snoop();
    snoop = 1; tick(); clear_in();
  endtask

  task automatic ack_flush(); flush_done = 1; tick(); clear_in(); endtask
  task automatic ack_save(); save_done = 1; tick(); clear_in(); endtask
  task automatic ack_restore(); restore_done = 1; tick(); clear_in(); endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tag = "R1"; tick(3); rst_n = 1; tick(3);
    tag = "R2"; hint(0); pulse_snoop(); tick(2);
    tag = "R6"; pulse_snoop(); tick();
    tag = "R7"; pulse_irq(); tick(2);
    tag = "R3"; pwr_rd_l2 = 1; tick(); clear_in(); tick(2); pulse_snoop(); ack_flush(); tick(2);
    tag = "R6"; pulse_snoop(); snoop = 1; tick(3); clear_in(); tick(2);
    tag = "R7"; pulse_irq(); tick(2);
    tag = "R3"; hint(1); tick(1); ack_flush(); tick(1);
    tag = "R7"; pulse_irq(); tick(1);
    tag = "R4"; pwr_rd_l3 = 1; tick(); clear_in(); tick(3); ack_save(); tick(3);
    tag = "R6"; pulse_snoop(); tick(1);
    tag = "R8"; pulse_irq(); tick(3); pulse_snoop(); ack_restore(); tick(2);
    tag = "R4"; hint(3); ack_save(); tick(1);
    tag = "R8"; pulse_irq(); ack_restore(); tick(1);
    tag = "R4"; hint(2); tick(1); ack_save();
    tag = "R8"; irq = 1; tick(); clear_in(); restore_done = 1; tick(); clear_in(); tick(1);
    tag = "R5"; wait_hint_vld = 1; wait_hint_lvl = 0; pwr_rd_l3 = 1; tick(); clear_in(); tick(1); ack_save(); pulse_irq(); ack_restore();
    tag = "R5"; pwr_rd_l2 = 1; wait_hint_vld = 1; wait_hint_lvl = 0; tick(); clear_in(); pwr_rd_l3 = 1; tick(); clear_in(); ack_flush(); tick(1);
    tag = "R5"; hint(3); pulse_irq(); tick(1);
    tag = "R5"; hint(0); pwr_rd_l2 = 1; tick(); pwr_rd_l3 = 1; tick(); clear_in(); pulse_irq(); tick(1);
    tag = "R5"; irq = 1; pwr_rd_l3 = 1; tick(); clear_in(); tick(2);
    tag = "R9"; pwr_rd_l2 = 1; tick(); clear_in(); pulse_irq(); tick(2); ack_flush(); tick(2);
    tag = "R9"; hint(2); tick(1); irq = 1; save_done = 1; tick(); clear_in(); tick(2);
    tag = "R9"; pwr_rd_l3 = 1; tick(); clear_in(); pulse_irq(); ack_save(); tick(2);
    tag = "R10"; hint(1); ack_flush(); pulse_irq(); hint(2); ack_save(); pulse_irq(); ack_restore(); tick(1);
    tag = "R1"; pwr_rd_l3 = 1; tick(); clear_in(); ack_save(); tick(1); rst_n = 0; tick(2); rst_n = 1; tick(3);
    tag = "R1"; hint(0); rst_n = 0; tick(); rst_n = 1; tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule